// File: doc/BRIEF.md
# Sync-Driven Channel Reset and Register Transfer Controller

This block sits in one channel of a multichannel digital receiver. It watches two asynchronous synchronisation inputs, A and B. On the rising edge of either input, it produces one-clock reset strobes for the channel's processing stages. It also copies double-buffered channel registers from their holding (master) copy into the active copy. A 32-bit control word, written by the host, selects which functions respond to each input. Its low half serves input A and its high half serves input B, and both halves use the same bit layout.

The host has a simple write port, `wr_en_i` / `wr_addr_i` / `wr_data_i`, with this address map:

| Address | Register |
|---|---|
| 0 | Control word |
| 1 | Datapath-control master |
| 2 | Carrier-frequency master |
| 3 | Gain master |
| 4 | Resampler-frequency master |
| 5 | Gain floor |
| 6 | Transfer strobe |

A write to the transfer strobe moves the masters selected by `wr_data_i[3:0]` into the active registers at once. Several channels or devices can share the sync wires, so all of them update on the same clock.

Top module: `sync_strobe_ctrl`

## Requirements
- R1: After reset, the control word, all masters, all active registers and the gain floor are zero, and every strobe output is low. With the control word at zero, neither sync input causes any output activity.
- R2: Each sync input passes through a two-flop synchroniser and an edge detector. The input is first sampled high at clock edge k. The strobes it causes are high during exactly one cycle, the cycle after edge k+2. No strobe is high after edge k+1. Holding the input high produces no further strobes.
- R3: Bit 15 of the control word enables input A and bit 31 enables input B. When the enable bit of a half is clear, that input causes no action. Bits 14 and 30 are reserved and never cause any action.
- R4: In an enabled half, half-bit b (b from 4 to 13) pulses `rst_pulse_o[b-4]`. The order from bit 0 to bit 9 of `rst_pulse_o` is: CIC, first FIR, second FIR, gain timing, gain processing, back end, resampler oscillators, leap counter, input FIFO, serial output. A sync input never acts on the half of the other input.
- R5: When both inputs fire in the same cycle, the outputs are the OR of the actions of both enabled halves.
- R6: In an enabled half, half-bit b (b from 0 to 3) pulses `load_pulse_o[b]`. In the same clock edge it copies the matching master into its active register. The order from bit 0 to bit 3 is: datapath control, carrier frequency, gain, resampler frequency.
- R7: A host write to address 6 pulses `load_pulse_o` equal to `wr_data_i[3:0]` in the cycle after the write edge. The selected active registers take their master values in that same cycle. This does not depend on the control word.
- R8: When a host write to a master and a transfer of that master occur at the same edge, the master takes the new value and the active register takes the old master value.
- R9: A gain-processing reset forces the active gain to the gain floor if the floor, read as a signed number, is above zero, and to zero otherwise. This takes precedence over a gain load at the same edge.
- R10: `sclk_div_rst_o` pulses together with the serial-output reset, but only if `sclk_rst_en_i` was high in the cycle of the sync event.
- R11: Writing a master, the floor or the control word leaves every active register unchanged and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_a_i | input | 1 | Asynchronous sync input A (low half of the control word) |
| sync_b_i | input | 1 | Asynchronous sync input B (high half of the control word) |
| wr_en_i | input | 1 | Host write enable |
| wr_addr_i | input | 3 | Host register address (0 to 6) |
| wr_data_i | input | 32 | Host write data |
| sclk_rst_en_i | input | 1 | Global enable for the serial clock divider reset |
| rst_pulse_o | output | 10 | One-cycle reset strobes for the processing stages |
| load_pulse_o | output | 4 | One-cycle master-to-active transfer strobes |
| sclk_div_rst_o | output | 1 | One-cycle serial clock divider reset |
| dp_ctrl_o | output | DP_W | Active datapath-control register |
| carrier_freq_o | output | FREQ_W | Active carrier frequency |
| gain_o | output | GAIN_W | Active gain value |
| rs_freq_o | output | FREQ_W | Active resampler frequency |

## Verification
The bench sweeps every bit of a half, one at a time, with the half's enable bit both set and clear. It runs this sweep in three ways:
- input A alone, with the B half fully populated;
- input B alone, with the A half fully populated;
- both inputs together, with a different bit in the other half.

This separates a wrong bit mapping, leakage between the halves, a broken OR merge and a missing enable gate. The sweep also varies the gain floor (negative, zero, positive) and the serial-divider enable, so the floor clipping and the divider gating are seen on their own. All sixteen transfer-strobe masks are written. The bench checks the sync latency one cycle early and one cycle late. It also covers a master write that coincides with a transfer, and a gain load that coincides with a gain reset.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam int HALF_W  = 16;
  localparam int EN_BIT  = 15;
  localparam int RSV_BIT = 14;
  localparam int RST_LO  = 4;
  localparam int N_RST   = 10;
  localparam int N_LD    = 4;

  localparam int RST_GAIN = 4;
  localparam int RST_SER  = 9;

  localparam int LD_DP   = 0;
  localparam int LD_CF   = 1;
  localparam int LD_GAIN = 2;
  localparam int LD_RS   = 3;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_DP     = 3'd1,
    A_CF     = 3'd2,
    A_GAIN   = 3'd3,
    A_RS     = 3'd4,
    A_FLOOR  = 3'd5,
    A_STROBE = 3'd6
  } hreg_e;

  typedef struct packed {
    logic [N_RST-1:0] rst;
    logic [N_LD-1:0]  ld;
  } act_req_t;

  // Actions requested by one half of the control word.
  function automatic act_req_t half_decode(input logic [HALF_W-1:0] h);
    act_req_t r;
    r.rst = '0;
    r.ld  = '0;
    if (h[EN_BIT]) begin
      r.rst = h[RST_LO +: N_RST];
      r.ld  = h[N_LD-1:0];
    end
    return r;
  endfunction

  // Gain value forced by a gain-processing reset: max(floor, 0), signed.
  function automatic logic [31:0] gain_floor_clip(input logic [31:0] f);
    return ($signed(f) > 0) ? f : 32'd0;
  endfunction

endpackage

// File: rtl/ssc_sync_edge.sv
module ssc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic event_o
);

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_i};
  end

  assign event_o = chain[STAGES-1] & ~chain[STAGES];

  // R2: an edge event is never two cycles long
  assert_event_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

endmodule

// File: rtl/ssc_req_merge.sv
module ssc_req_merge
  import ssc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ctrl_i,
  input  logic             ev_a_i,
  input  logic             ev_b_i,
  input  logic             strobe_i,
  input  logic [N_LD-1:0]  strobe_ld_i,
  input  logic             sclk_en_i,
  output logic [N_RST-1:0] rst_req_o,
  output logic [N_LD-1:0]  ld_req_o,
  output logic [N_RST-1:0] rst_pulse_o,
  output logic [N_LD-1:0]  ld_pulse_o,
  output logic             sclk_rst_o
);

  act_req_t req_a, req_b;

  always_comb begin
    req_a     = ev_a_i ? half_decode(ctrl_i[HALF_W-1:0])        : '0;
    req_b     = ev_b_i ? half_decode(ctrl_i[2*HALF_W-1:HALF_W]) : '0;
    rst_req_o = req_a.rst | req_b.rst;
    ld_req_o  = req_a.ld | req_b.ld | (strobe_i ? strobe_ld_i : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_pulse_o <= '0;
      ld_pulse_o  <= '0;
      sclk_rst_o  <= 1'b0;
    end else begin
      rst_pulse_o <= rst_req_o;
      ld_pulse_o  <= ld_req_o;
      sclk_rst_o  <= rst_req_o[RST_SER] & sclk_en_i;
    end
  end

  // R2: no strobe without an event in the previous cycle
  assert_no_idle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_a_i && !ev_b_i && !strobe_i) |=> (rst_pulse_o == '0 && ld_pulse_o == '0));

  // R4: reset strobes come only from sync events
  assert_rst_needs_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_a_i && !ev_b_i) |=> (rst_pulse_o == '0));

  // R10: divider reset only alongside the serial-output reset
  assert_sclk_with_serial_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rst_o |-> rst_pulse_o[RST_SER]);

  // R10: divider reset needs the enable in the event cycle
  assert_sclk_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en_i |=> !sclk_rst_o);

endmodule

// File: rtl/ssc_shadow_reg.sv
module ssc_shadow_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mst_we_i,
  input  logic [W-1:0] mst_d_i,
  input  logic         load_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_val_i,
  output logic [W-1:0] act_o
);

  logic [W-1:0] mst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_q <= '0;
      act_o <= '0;
    end else begin
      if (mst_we_i) mst_q <= mst_d_i;
      if (clr_i)       act_o <= clr_val_i;
      else if (load_i) act_o <= mst_q;
    end
  end

  // R6 / R8: a transfer takes the master value held before the edge
  assert_load_old_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> act_o == $past(mst_q));

  // R9: a forced value wins over a load
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> act_o == $past(clr_val_i));

  // R11: active copy holds without a transfer or clear
  assert_active_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i) |=> $stable(act_o));

endmodule

// File: rtl/sync_strobe_ctrl.sv
module sync_strobe_ctrl
  import ssc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DP_W        = 32,
  parameter int FREQ_W      = 32,
  parameter int GAIN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              sclk_rst_en_i,
  output logic [N_RST-1:0]  rst_pulse_o,
  output logic [N_LD-1:0]   load_pulse_o,
  output logic              sclk_div_rst_o,
  output logic [DP_W-1:0]   dp_ctrl_o,
  output logic [FREQ_W-1:0] carrier_freq_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [FREQ_W-1:0] rs_freq_o
);

  localparam int N_SYNC = 2;

  // Host register decode.
  hreg_e wsel;
  logic  we_ctrl, we_dp, we_cf, we_gain, we_rs, we_floor;
  logic  ev_strobe;

  assign wsel      = hreg_e'(wr_addr_i);
  assign we_ctrl   = wr_en_i && (wsel == A_CTRL);
  assign we_dp     = wr_en_i && (wsel == A_DP);
  assign we_cf     = wr_en_i && (wsel == A_CF);
  assign we_gain   = wr_en_i && (wsel == A_GAIN);
  assign we_rs     = wr_en_i && (wsel == A_RS);
  assign we_floor  = wr_en_i && (wsel == A_FLOOR);
  assign ev_strobe = wr_en_i && (wsel == A_STROBE);

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[31:N_LD], wr_data_i[31:GAIN_W]};

  // Control word with the reserved bits held at zero.
  logic [31:0] ctrl_q;
  logic [31:0] rsv_mask;
  assign rsv_mask = ~((32'd1 << RSV_BIT) | (32'd1 << (RSV_BIT + HALF_W)));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= wr_data_i & rsv_mask;
  end

  // Gain floor, not double-buffered.
  logic [GAIN_W-1:0] floor_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        floor_q <= '0;
    else if (we_floor) floor_q <= wr_data_i[GAIN_W-1:0];
  end

  // Sync input conditioning, one synchroniser per input.
  logic [N_SYNC-1:0] sync_pins;
  logic [N_SYNC-1:0] sync_ev;
  assign sync_pins = {sync_b_i, sync_a_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    ssc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sync_pins[g]),
      .event_o (sync_ev[g])
    );
  end

  logic ev_sync_a, ev_sync_b;
  assign ev_sync_a = sync_ev[0];
  assign ev_sync_b = sync_ev[1];

  // Request merge and strobe registers.
  logic [N_RST-1:0] rst_req;
  logic [N_LD-1:0]  ld_req;

  ssc_req_merge u_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_q),
    .ev_a_i      (ev_sync_a),
    .ev_b_i      (ev_sync_b),
    .strobe_i    (ev_strobe),
    .strobe_ld_i (wr_data_i[N_LD-1:0]),
    .sclk_en_i   (sclk_rst_en_i),
    .rst_req_o   (rst_req),
    .ld_req_o    (ld_req),
    .rst_pulse_o (rst_pulse_o),
    .ld_pulse_o  (load_pulse_o),
    .sclk_rst_o  (sclk_div_rst_o)
  );

  // Gain value forced by a gain-processing reset.
  logic [31:0]       floor_sext;
  logic [31:0]       floor_clip;
  logic [GAIN_W-1:0] gain_force_val;
  logic              gain_force;

  assign floor_sext     = {{(32-GAIN_W){floor_q[GAIN_W-1]}}, floor_q};
  assign floor_clip     = gain_floor_clip(floor_sext);
  assign gain_force_val = floor_clip[GAIN_W-1:0];
  assign gain_force     = rst_req[RST_GAIN];

  // Double-buffered registers.
  ssc_shadow_reg #(.W(DP_W)) u_dp (
    .clk (clk), .rst_n (rst_n),
    .mst_we_i (we_dp), .mst_d_i (wr_data_i[DP_W-1:0]),
    .load_i (ld_req[LD_DP]), .clr_i (1'b0), .clr_val_i ('0),
    .act_o (dp_ctrl_o)
  );

  ssc_shadow_reg #(.W(FREQ_W)) u_cf (
    .clk (clk), .rst_n (rst_n),
    .mst_we_i (we_cf), .mst_d_i (wr_data_i[FREQ_W-1:0]),
    .load_i (ld_req[LD_CF]), .clr_i (1'b0), .clr_val_i ('0),
    .act_o (carrier_freq_o)
  );

  ssc_shadow_reg #(.W(GAIN_W)) u_gain (
    .clk (clk), .rst_n (rst_n),
    .mst_we_i (we_gain), .mst_d_i (wr_data_i[GAIN_W-1:0]),
    .load_i (ld_req[LD_GAIN]), .clr_i (gain_force), .clr_val_i (gain_force_val),
    .act_o (gain_o)
  );

  ssc_shadow_reg #(.W(FREQ_W)) u_rs (
    .clk (clk), .rst_n (rst_n),
    .mst_we_i (we_rs), .mst_d_i (wr_data_i[FREQ_W-1:0]),
    .load_i (ld_req[LD_RS]), .clr_i (1'b0), .clr_val_i ('0),
    .act_o (rs_freq_o)
  );

  // R3: with both enables clear, syncs cause no reset strobe
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[EN_BIT] && !ctrl_q[EN_BIT + HALF_W]) |=> (rst_pulse_o == '0));

  // R9: a forced gain is never negative
  assert_gain_not_negative_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gain_force |=> !gain_o[GAIN_W-1]);

  // R7: a strobe write shows its mask on the load strobes
  assert_strobe_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |=> ((load_pulse_o & $past(wr_data_i[N_LD-1:0])) == $past(wr_data_i[N_LD-1:0])));

endmodule

// File: tb/sim_sync_strobe_ctrl.sv
module sim_sync_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_a = 1'b0, sync_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        sclk_en = 1'b0;
  logic [9:0]  rst_pulse;
  logic [3:0]  load_pulse;
  logic        sclk_rst;
  logic [31:0] dp_o, cf_o, rs_o;
  logic [15:0] gain_o;

  always #2 clk = ~clk;

  sync_strobe_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .sync_a_i (sync_a), .sync_b_i (sync_b),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .sclk_rst_en_i (sclk_en), .rst_pulse_o (rst_pulse), .load_pulse_o (load_pulse),
    .sclk_div_rst_o (sclk_rst), .dp_ctrl_o (dp_o), .carrier_freq_o (cf_o),
    .gain_o (gain_o), .rs_freq_o (rs_o)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // Bench copies of masters, floor and expected active values.
  logic [31:0] m_dp = 0, m_cf = 0, m_rs = 0;
  logic [15:0] m_gain = 0, fl = 0;
  logic [31:0] e_dp = 0, e_cf = 0, e_rs = 0;
  logic [15:0] e_gain = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input logic [9:0] er, input logic [3:0] el,
                           input bit es, input string req);
    chk(rst_pulse == er,  req, "rst_pulse",  {22'd0, rst_pulse}, {22'd0, er});
    chk(load_pulse == el, req, "load_pulse", {28'd0, load_pulse}, {28'd0, el});
    chk(sclk_rst == es,   req, "sclk_rst",   {31'd0, sclk_rst}, {31'd0, es});
    chk(dp_o == e_dp,     req, "dp_ctrl",    dp_o, e_dp);
    chk(cf_o == e_cf,     req, "carrier",    cf_o, e_cf);
    chk(gain_o == e_gain, req, "gain",       {16'd0, gain_o}, {16'd0, e_gain});
    chk(rs_o == e_rs,     req, "rs_freq",    rs_o, e_rs);
  endtask

  // Starts and ends just after a falling edge; the write lands on the rising edge between.
  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
    case (a)
      3'd1: m_dp = d;
      3'd2: m_cf = d;
      3'd3: m_gain = d[15:0];
      3'd4: m_rs = d;
      3'd5: fl = d[15:0];
      default: ;
    endcase
  endtask

  // Spec decode of one half: bits 0..3 are loads, 4..13 resets, 15 the enable.
  task automatic half_exp(input logic [15:0] h, inout logic [9:0] er, inout logic [3:0] el);
    if (h[15]) begin
      for (int i = 0; i < 14; i++) begin
        if (((h >> i) & 16'd1) != 0) begin
          if (i < 4) el = el | (4'd1 << i);
          else       er = er | (10'd1 << (i - 4));
        end
      end
    end
  endtask

  task automatic apply_model(input logic [9:0] er, input logic [3:0] el);
    if (el[0]) e_dp = m_dp;
    if (el[1]) e_cf = m_cf;
    if (el[2]) e_gain = m_gain;
    if (el[3]) e_rs = m_rs;
    if (er[4]) e_gain = ($signed(fl) > 0) ? fl : 16'd0;
  endtask

  // Raise the pins, check one cycle early, on time and one cycle late.
  task automatic fire(input bit a, input bit b, input logic [9:0] er,
                      input logic [3:0] el, input bit es, input string req);
    sync_a = a; sync_b = b;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_all(10'd0, 4'd0, 1'b0, "R2 early");
    @(posedge clk); @(negedge clk);
    apply_model(er, el);
    check_all(er, el, es, req);
    @(posedge clk); @(negedge clk);
    check_all(10'd0, 4'd0, 1'b0, "R2 held");
    sync_a = 1'b0; sync_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, and syncs inert with a zero control word
    check_all(10'd0, 4'd0, 1'b0, "R1");
    sclk_en = 1'b1;
    fire(1'b1, 1'b1, 10'd0, 4'd0, 1'b0, "R1");

    // Sweep: every half bit, enable on/off, A alone, B alone, both
    for (int src = 0; src < 3; src++) begin
      for (int en = 0; en < 2; en++) begin
        for (int b = 0; b < 16; b++) begin
          int it;
          logic [15:0] half, other;
          logic [9:0] er;
          logic [3:0] el;
          string tag;
          it = src * 32 + en * 16 + b;
          half  = (en != 0 ? 16'h8000 : 16'h0000) | (16'd1 << b);
          other = (en != 0) ? (16'h8000 | (16'd1 << ((b + 5) % 14))) : 16'h0000;
          host_write(3'd1, 32'h1000_0000 + it);
          host_write(3'd2, 32'h2000_0000 + it);
          host_write(3'd3, 32'h0000_0100 + it);
          host_write(3'd4, 32'h4000_0000 + it);
          case (it % 3)
            0:       host_write(3'd5, 32'h0000_FFF0);
            1:       host_write(3'd5, 32'd7 + it);
            default: host_write(3'd5, 32'd0);
          endcase
          sclk_en = it[0];
          case (src)
            0:       host_write(3'd0, {16'hBFFF, half});
            1:       host_write(3'd0, {half, 16'hBFFF});
            default: host_write(3'd0, {other, half});
          endcase
          check_all(10'd0, 4'd0, 1'b0, "R11");
          er = 10'd0; el = 4'd0;
          half_exp(half, er, el);
          if (src == 2) half_exp(other, er, el);
          if (en == 0 || b == 14) tag = "R3";
          else if (src == 2)      tag = "R5";
          else if (b < 4)         tag = "R6";
          else if (b == 8)        tag = "R9";
          else if (b == 13)       tag = "R10";
          else                    tag = "R4";
          fire(src != 1, src != 0, er, el, er[9] & sclk_en, tag);
        end
      end
    end

    // R7: every strobe mask, with the control word cleared
    host_write(3'd0, 32'd0);
    for (int s = 0; s < 16; s++) begin
      host_write(3'd1, 32'hA000_0000 + s);
      host_write(3'd2, 32'hB000_0000 + s);
      host_write(3'd3, 32'h0000_0300 + s);
      host_write(3'd4, 32'hC000_0000 + s);
      check_all(10'd0, 4'd0, 1'b0, "R11");
      host_write(3'd6, s);
      apply_model(10'd0, s[3:0]);
      check_all(10'd0, s[3:0], 1'b0, "R7");
      @(posedge clk); @(negedge clk);
      check_all(10'd0, 4'd0, 1'b0, "R7 single");
    end

    // R8: master write on the same edge as a sync transfer
    host_write(3'd0, 32'h0000_8001);
    host_write(3'd1, 32'h1111_1111);
    sync_a = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h2222_2222;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
    e_dp = m_dp;
    m_dp = 32'h2222_2222;
    check_all(10'd0, 4'd1, 1'b0, "R8");
    sync_a = 1'b0;
    repeat (3) @(negedge clk);
    host_write(3'd6, 32'd1);
    e_dp = m_dp;
    check_all(10'd0, 4'd0 | 4'd1, 1'b0, "R8 new master");

    // R9: gain reset and gain load together, positive then negative floor
    host_write(3'd0, 32'h8104_0000);
    host_write(3'd3, 32'h0000_0777);
    host_write(3'd5, 32'h0000_0123);
    sclk_en = 1'b0;
    fire(1'b0, 1'b1, 10'h010, 4'h4, 1'b0, "R9");
    chk(gain_o == 16'h0123, "R9", "gain floor", {16'd0, gain_o}, 32'h123);
    host_write(3'd5, 32'h0000_8000);
    fire(1'b0, 1'b1, 10'h010, 4'h4, 1'b0, "R9");
    chk(gain_o == 16'h0000, "R9", "gain zero", {16'd0, gain_o}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule